// File: doc/BRIEF.md
# Store-to-Load Address Overlap Detector

This block remembers the address description of the most recent store issued in the current instruction group. It then tells the scheduler, for every later load in that group, whether the load may read bytes that the store writes. An address is written as two operands. Each operand is either a register tag or a signed constant offset, marked by a per-operand constant flag. Two operands are equal when their constant flags agree and their 16-bit values agree.

A load counts as a hit in three cases: its operand pair equals the stored pair in the same order; the pair equals it with the two operands swapped; or the second operands are equal, both first operands are constants, and the two byte ranges intersect. The range test uses signed offsets. Each access is either a word of 4 bytes or a double of 8 bytes. A store capture strobe replaces the record, and a group-clear strobe erases it. A load request gets its answer on a registered valid/hit pair one clock later. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `sd_ovl_detect`

## Requirements
- R1: While reset is active and until the first load request after reset, `ovl_vld_o` and `ovl_hit_o` are 0, and no store is recorded.
- R2: `ovl_vld_o` is 1 in the cycle after each clock edge that samples `ld_req_i` high, and 0 after any edge that samples it low. `ovl_hit_o` is 1 only together with `ovl_vld_o`.
- R3: With no store recorded, after reset or after a clear, every load reports `ovl_hit_o` = 0.
- R4: A load whose first and second operands equal the recorded first and second operands reports a hit. Equality means the same constant flag and the same 16-bit value, so a register tag never equals a constant of the same value.
- R5: A load whose first operand equals the recorded second operand, and whose second operand equals the recorded first operand, reports a hit.
- R6: When the second operands are equal and both first operands are constants, the constants are signed 16-bit offsets. The hit is decided by byte-range intersection.
- R7: In the R6 case, when the store offset is below the load offset, the load hits if and only if store offset plus store size is greater than the load offset.
- R8: In the R6 case, when the store offset is not below the load offset, the load hits if and only if load offset plus load size is greater than the store offset.
- R9: A size flag of 0 means a 4-byte word and 1 means an 8-byte double, for stores (`st_dbl_i`) and loads (`ld_dbl_i`) alike.
- R10: A new store capture replaces the previous record entirely, so a load matching only the old store reports 0.
- R11: A clear erases the record. When a clear and a capture fall on the same edge, the capture wins and the new store is recorded.
- R12: A load sampled on the same edge as a capture or a clear is judged against the record as it stood before that edge.
- R13: When none of the R4, R5 or R6 conditions hold, for example a different second operand, or a register first operand that does not match exactly, the load reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_cap_i | input | 1 | Record the store described on the st_* inputs |
| st_a_c_i | input | 1 | Store first operand is a constant |
| st_a_v_i | input | 16 | Store first operand tag or offset |
| st_b_c_i | input | 1 | Store second operand is a constant |
| st_b_v_i | input | 16 | Store second operand tag or offset |
| st_dbl_i | input | 1 | Store size: 0 word (4 B), 1 double (8 B) |
| grp_clr_i | input | 1 | End of group: erase the recorded store |
| ld_req_i | input | 1 | Load query valid |
| ld_a_c_i | input | 1 | Load first operand is a constant |
| ld_a_v_i | input | 16 | Load first operand tag or offset |
| ld_b_c_i | input | 1 | Load second operand is a constant |
| ld_b_v_i | input | 16 | Load second operand tag or offset |
| ld_dbl_i | input | 1 | Load size: 0 word (4 B), 1 double (8 B) |
| ovl_vld_o | output | 1 | Answer to the load sampled on the previous edge |
| ovl_hit_o | output | 1 | That load overlaps the recorded store |

## Verification
A load query can arrive on the same edge as a store capture or a group clear. That makes the ordering between updating the record and reading it the delicate point. The bench drives both pairs on one edge: a capture with a load that matches only the new store, and a clear with a load that matches the old store. The scoreboard expects the answer from the record as it stood before the edge, so a design that forwards the new record, or drops the old one early, is reported. The clear-plus-capture edge is provoked the same way, and is judged by a load on the following cycle.

// File: rtl/sd_ovl_pkg.sv
package sd_ovl_pkg;

  parameter int unsigned SD_VAL_W = 16;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_DBL  = 1'b1
  } acc_sz_e;

  function automatic int unsigned sz_bytes(input acc_sz_e sz,
                                           input int unsigned word_b,
                                           input int unsigned dbl_b);
    return (sz == SZ_DBL) ? dbl_b : word_b;
  endfunction

endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/sd_store_rec.sv
module sd_store_rec #(
  parameter int unsigned VAL_W = 16,
  localparam int unsigned OPD_W = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             clr_i,
  input  logic [OPD_W-1:0] a_i,
  input  logic [OPD_W-1:0] b_i,
  input  logic             dbl_i,
  output logic             vld_o,
  output logic [OPD_W-1:0] a_o,
  output logic [OPD_W-1:0] b_o,
  output logic             dbl_o
);

  logic             vld_q, vld_d;
  logic [OPD_W-1:0] a_q, a_d, b_q, b_d;
  logic             dbl_q, dbl_d;
  logic             en;

  // capture has priority over clear
  always_comb begin
    en    = cap_i | clr_i;
    vld_d = vld_q;
    a_d   = a_q;
    b_d   = b_q;
    dbl_d = dbl_q;
    if (cap_i) begin
      vld_d = 1'b1;
      a_d   = a_i;
      b_d   = b_i;
      dbl_d = dbl_i;
    end else if (clr_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
      dbl_q <= 1'b0;
    end else if (en) begin
      vld_q <= vld_d;
      a_q   <= a_d;
      b_q   <= b_d;
      dbl_q <= dbl_d;
    end
  end

  assign vld_o = vld_q;
  assign a_o   = a_q;
  assign b_o   = b_q;
  assign dbl_o = dbl_q;

endmodule

// File: rtl/sd_opnd_eq.sv
module sd_opnd_eq #(
  parameter int unsigned VAL_W = 16,
  localparam int unsigned OPD_W = VAL_W + 1
) (
  input  logic [OPD_W-1:0] lhs_i,
  input  logic [OPD_W-1:0] rhs_i,
  output logic             eq_o
);

  // operand = {is_const, value}; kind and value must both agree
  logic kind_eq;
  logic val_eq;

  always_comb begin
    kind_eq = (lhs_i[OPD_W-1] == rhs_i[OPD_W-1]);
    val_eq  = (lhs_i[VAL_W-1:0] == rhs_i[VAL_W-1:0]);
    eq_o    = kind_eq & val_eq;
  end

endmodule

// File: rtl/sd_range_ovl.sv
module sd_range_ovl
  import sd_ovl_pkg::*;
#(
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned DBL_BYTES  = 8,
  localparam int unsigned SUM_W     = VAL_W + $clog2(DBL_BYTES + 1) + 1
) (
  input  logic [VAL_W-1:0] st_off_i,
  input  logic             st_dbl_i,
  input  logic [VAL_W-1:0] ld_off_i,
  input  logic             ld_dbl_i,
  output logic             ovl_o
);

  localparam int unsigned EXT_W = SUM_W - VAL_W;

  logic signed [SUM_W-1:0] st_off_x, ld_off_x;
  logic signed [SUM_W-1:0] st_sz, ld_sz;
  logic signed [SUM_W-1:0] st_end, ld_end;
  logic                    st_below;

  always_comb begin
    st_off_x = {{EXT_W{st_off_i[VAL_W-1]}}, st_off_i};
    ld_off_x = {{EXT_W{ld_off_i[VAL_W-1]}}, ld_off_i};
    st_sz    = SUM_W'(sz_bytes(acc_sz_e'(st_dbl_i), WORD_BYTES, DBL_BYTES));
    ld_sz    = SUM_W'(sz_bytes(acc_sz_e'(ld_dbl_i), WORD_BYTES, DBL_BYTES));
    st_end   = st_off_x + st_sz;
    ld_end   = ld_off_x + ld_sz;
    st_below = (st_off_x < ld_off_x);
    ovl_o    = st_below ? (st_end > ld_off_x) : (ld_end > st_off_x);
  end

endmodule

// File: rtl/sd_ovl_detect.sv
module sd_ovl_detect
  import sd_ovl_pkg::*;
#(
  parameter int unsigned VAL_W       = SD_VAL_W,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned DBL_BYTES   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             st_cap_i,
  input  logic             st_a_c_i,
  input  logic [VAL_W-1:0] st_a_v_i,
  input  logic             st_b_c_i,
  input  logic [VAL_W-1:0] st_b_v_i,
  input  logic             st_dbl_i,
  input  logic             grp_clr_i,
  input  logic             ld_req_i,
  input  logic             ld_a_c_i,
  input  logic [VAL_W-1:0] ld_a_v_i,
  input  logic             ld_b_c_i,
  input  logic [VAL_W-1:0] ld_b_v_i,
  input  logic             ld_dbl_i,
  output logic             ovl_vld_o,
  output logic             ovl_hit_o
);

  localparam int unsigned OPD_W  = VAL_W + 1;
  localparam int unsigned N_CMP  = 4;

  logic rst_sync_n;

  sd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  logic [OPD_W-1:0] st_a, st_b, ld_a, ld_b;
  logic             rec_vld, rec_dbl;
  logic [OPD_W-1:0] rec_a, rec_b;

  assign st_a = {st_a_c_i, st_a_v_i};
  assign st_b = {st_b_c_i, st_b_v_i};
  assign ld_a = {ld_a_c_i, ld_a_v_i};
  assign ld_b = {ld_b_c_i, ld_b_v_i};

  sd_store_rec #(.VAL_W(VAL_W)) u_rec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cap_i (st_cap_i),
    .clr_i (grp_clr_i),
    .a_i   (st_a),
    .b_i   (st_b),
    .dbl_i (st_dbl_i),
    .vld_o (rec_vld),
    .a_o   (rec_a),
    .b_o   (rec_b),
    .dbl_o (rec_dbl)
  );

  // comparator k: 0 la/ra, 1 lb/rb, 2 la/rb, 3 lb/ra
  logic [OPD_W-1:0] cmp_l [N_CMP];
  logic [OPD_W-1:0] cmp_r [N_CMP];
  logic [N_CMP-1:0] cmp_eq;

  always_comb begin
    cmp_l[0] = ld_a;  cmp_r[0] = rec_a;
    cmp_l[1] = ld_b;  cmp_r[1] = rec_b;
    cmp_l[2] = ld_a;  cmp_r[2] = rec_b;
    cmp_l[3] = ld_b;  cmp_r[3] = rec_a;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    sd_opnd_eq #(.VAL_W(VAL_W)) u_eq (
      .lhs_i (cmp_l[k]),
      .rhs_i (cmp_r[k]),
      .eq_o  (cmp_eq[k])
    );
  end

  logic rng_ovl;

  sd_range_ovl #(
    .VAL_W      (VAL_W),
    .WORD_BYTES (WORD_BYTES),
    .DBL_BYTES  (DBL_BYTES)
  ) u_rng (
    .st_off_i (rec_a[VAL_W-1:0]),
    .st_dbl_i (rec_dbl),
    .ld_off_i (ld_a_v_i),
    .ld_dbl_i (ld_dbl_i),
    .ovl_o    (rng_ovl)
  );

  logic same_ord, swap_ord, rng_en, hit_d, vld_d;
  logic vld_q, hit_q;

  always_comb begin
    same_ord = cmp_eq[0] & cmp_eq[1];
    swap_ord = cmp_eq[2] & cmp_eq[3];
    rng_en   = cmp_eq[1] & ld_a[OPD_W-1] & rec_a[OPD_W-1];
    vld_d    = ld_req_i;
    hit_d    = ld_req_i & rec_vld & (same_ord | swap_ord | (rng_en & rng_ovl));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      hit_q <= hit_d;
    end
  end

  assign ovl_vld_o = vld_q;
  assign ovl_hit_o = hit_q;

endmodule

// File: rtl/sd_ovl_detect_chk.sv
module sd_ovl_detect_chk #(
  parameter int unsigned VAL_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             st_cap_i,
  input logic             st_a_c_i,
  input logic [VAL_W-1:0] st_a_v_i,
  input logic             st_b_c_i,
  input logic [VAL_W-1:0] st_b_v_i,
  input logic             grp_clr_i,
  input logic             ld_req_i,
  input logic             ld_a_c_i,
  input logic [VAL_W-1:0] ld_a_v_i,
  input logic             ld_b_c_i,
  input logic [VAL_W-1:0] ld_b_v_i,
  input logic             ovl_vld_o,
  input logic             ovl_hit_o
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_req_i |=> ovl_vld_o); // R2

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_req_i |=> !ovl_vld_o); // R2

  AST_HIT_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovl_hit_o |-> ovl_vld_o); // R2

  AST_CLEARED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(grp_clr_i && !st_cap_i) && ld_req_i) |=> !ovl_hit_o); // R3

  AST_SAME_ORDER_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(st_cap_i) && ld_req_i &&
     ld_a_c_i == $past(st_a_c_i) && ld_a_v_i == $past(st_a_v_i) &&
     ld_b_c_i == $past(st_b_c_i) && ld_b_v_i == $past(st_b_v_i)) |=> ovl_hit_o); // R4

  AST_SWAP_ORDER_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(st_cap_i) && ld_req_i &&
     ld_a_c_i == $past(st_b_c_i) && ld_a_v_i == $past(st_b_v_i) &&
     ld_b_c_i == $past(st_a_c_i) && ld_b_v_i == $past(st_a_v_i)) |=> ovl_hit_o); // R5

  AST_CAP_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(st_cap_i && grp_clr_i) && ld_req_i &&
     ld_a_c_i == $past(st_a_c_i) && ld_a_v_i == $past(st_a_v_i) &&
     ld_b_c_i == $past(st_b_c_i) && ld_b_v_i == $past(st_b_v_i)) |=> ovl_hit_o); // R11

endmodule

bind sd_ovl_detect sd_ovl_detect_chk #(.VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .st_cap_i   (st_cap_i),
  .st_a_c_i   (st_a_c_i),
  .st_a_v_i   (st_a_v_i),
  .st_b_c_i   (st_b_c_i),
  .st_b_v_i   (st_b_v_i),
  .grp_clr_i  (grp_clr_i),
  .ld_req_i   (ld_req_i),
  .ld_a_c_i   (ld_a_c_i),
  .ld_a_v_i   (ld_a_v_i),
  .ld_b_c_i   (ld_b_c_i),
  .ld_b_v_i   (ld_b_v_i),
  .ovl_vld_o  (ovl_vld_o),
  .ovl_hit_o  (ovl_hit_o)
);

// File: tb/sd_ovl_detect_test.sv
`timescale 1ns/1ps
module sd_ovl_detect_test;

  typedef struct packed {
    logic        c;
    logic [15:0] v;
  } opd_t;

  typedef struct {
    bit    hit;
    string tag;
  } exp_t;

  logic        clk;
  logic        rst_ni;
  logic        st_cap_i, st_a_c_i, st_b_c_i, st_dbl_i, grp_clr_i;
  logic [15:0] st_a_v_i, st_b_v_i;
  logic        ld_req_i, ld_a_c_i, ld_b_c_i, ld_dbl_i;
  logic [15:0] ld_a_v_i, ld_b_v_i;
  logic        ovl_vld_o, ovl_hit_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit mon_on   = 0;
  exp_t sb_q[$];

  // bench-side model of the recorded store
  bit   m_vld = 0;
  opd_t m_a, m_b;
  bit   m_dbl;

  sd_ovl_detect uut (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .st_cap_i  (st_cap_i),
    .st_a_c_i  (st_a_c_i),
    .st_a_v_i  (st_a_v_i),
    .st_b_c_i  (st_b_c_i),
    .st_b_v_i  (st_b_v_i),
    .st_dbl_i  (st_dbl_i),
    .grp_clr_i (grp_clr_i),
    .ld_req_i  (ld_req_i),
    .ld_a_c_i  (ld_a_c_i),
    .ld_a_v_i  (ld_a_v_i),
    .ld_b_c_i  (ld_b_c_i),
    .ld_b_v_i  (ld_b_v_i),
    .ld_dbl_i  (ld_dbl_i),
    .ovl_vld_o (ovl_vld_o),
    .ovl_hit_o (ovl_hit_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic opd_t rg(input int v);
    return '{c: 1'b0, v: v[15:0]};
  endfunction

  function automatic opd_t cn(input int v);
    return '{c: 1'b1, v: v[15:0]};
  endfunction

  function automatic bit ref_hit(input opd_t la, input opd_t lb, input bit ldbl);
    int so, lo, ss, ls;
    if (!m_vld) return 1'b0;
    if (la == m_a && lb == m_b) return 1'b1;
    if (la == m_b && lb == m_a) return 1'b1;
    if (lb == m_b && la.c && m_a.c) begin
      so = int'($signed(m_a.v));
      lo = int'($signed(la.v));
      ss = m_dbl ? 8 : 4;
      ls = ldbl ? 8 : 4;
      if (so < lo) return (so + ss > lo);
      return (lo + ls > so);
    end
    return 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input bit cap, input opd_t sa, input opd_t sb, input bit sdbl,
                      input bit clr, input bit req, input opd_t la, input opd_t lb,
                      input bit ldbl, input string tag);
    exp_t e;
    @(negedge clk);
    st_cap_i  = cap;
    st_a_c_i  = sa.c;  st_a_v_i = sa.v;
    st_b_c_i  = sb.c;  st_b_v_i = sb.v;
    st_dbl_i  = sdbl;
    grp_clr_i = clr;
    ld_req_i  = req;
    ld_a_c_i  = la.c;  ld_a_v_i = la.v;
    ld_b_c_i  = lb.c;  ld_b_v_i = lb.v;
    ld_dbl_i  = ldbl;
    if (req) begin
      e.hit = ref_hit(la, lb, ldbl);
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (cap) begin
      m_vld = 1'b1; m_a = sa; m_b = sb; m_dbl = sdbl;
    end else if (clr) begin
      m_vld = 1'b0;
    end
  endtask

  task automatic do_store(input opd_t sa, input opd_t sb, input bit dbl);
    step(1'b1, sa, sb, dbl, 1'b0, 1'b0, rg(0), rg(0), 1'b0, "");
  endtask

  task automatic do_load(input opd_t la, input opd_t lb, input bit dbl, input string tag);
    step(1'b0, rg(0), rg(0), 1'b0, 1'b0, 1'b1, la, lb, dbl, tag);
  endtask

  task automatic do_clear();
    step(1'b0, rg(0), rg(0), 1'b0, 1'b1, 1'b0, rg(0), rg(0), 1'b0, "");
  endtask

  task automatic idle();
    step(1'b0, rg(0), rg(0), 1'b0, 1'b0, 1'b0, rg(0), rg(0), 1'b0, "");
  endtask

  // monitor: pops and compares as the design answers
  always @(negedge clk) begin
    if (mon_on) begin
      if (ovl_vld_o) begin
        if (sb_q.size() == 0) begin
          check("R2 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, int'(ovl_hit_o), int'(e.hit));
        end
      end else if (ovl_hit_o) begin
        check("R2 hit without valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    st_cap_i = 0; st_a_c_i = 0; st_a_v_i = 0; st_b_c_i = 0; st_b_v_i = 0; st_dbl_i = 0;
    grp_clr_i = 0; ld_req_i = 0; ld_a_c_i = 0; ld_a_v_i = 0; ld_b_c_i = 0; ld_b_v_i = 0;
    ld_dbl_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 vld in reset", int'(ovl_vld_o), 0);
    check("R1 hit in reset", int'(ovl_hit_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 vld after release", int'(ovl_vld_o), 0);
    mon_on = 1'b1;

    do_load(cn(8), rg(5), 1'b0, "R1 R3 load with nothing recorded");

    // store word at [8 + r5]
    do_store(cn(8), rg(5), 1'b0);
    do_load(cn(8), rg(5), 1'b0, "R4 same order");
    do_load(rg(5), cn(8), 1'b0, "R5 swapped order");
    do_load(rg(8), rg(5), 1'b0, "R4 R13 tag vs const same value");
    do_load(cn(12), rg(5), 1'b1, "R7 word store ends at load offset");
    do_store(cn(8), rg(5), 1'b1);
    do_load(cn(12), rg(5), 1'b0, "R7 R9 double store reaches load");
    do_load(cn(4), rg(5), 1'b0, "R8 word load ends at store offset");
    do_load(cn(4), rg(5), 1'b1, "R8 R9 double load reaches store");

    // negative offsets
    do_store(cn(-4), rg(5), 1'b0);
    do_load(cn(-8), rg(5), 1'b1, "R6 R8 signed double load");
    do_load(cn(-8), rg(5), 1'b0, "R6 R8 signed word load touching");
    do_load(cn(-2), rg(5), 1'b0, "R6 R7 signed store below load");
    do_load(cn(-4), rg(6), 1'b0, "R13 other base");
    do_load(rg(7), rg(5), 1'b0, "R13 register first operand");

    // register pair store
    do_store(rg(3), rg(4), 1'b1);
    do_load(rg(4), rg(3), 1'b0, "R5 register pair swapped");
    do_load(rg(3), rg(9), 1'b0, "R13 second operand differs");

    // replacement
    do_store(cn(100), rg(9), 1'b0);
    do_load(rg(3), rg(4), 1'b1, "R10 old record gone");
    do_load(cn(100), rg(9), 1'b0, "R10 new record present");

    // clear
    do_clear();
    do_load(cn(100), rg(9), 1'b0, "R11 R3 cleared record");

    // capture and load on one edge: load sees the empty record
    step(1'b1, cn(20), rg(2), 1'b0, 1'b0, 1'b1, cn(20), rg(2), 1'b0,
         "R12 load with capture sees old record");
    do_load(cn(20), rg(2), 1'b0, "R12 next load sees new record");

    // clear and load on one edge: load still sees the record
    step(1'b0, rg(0), rg(0), 1'b0, 1'b1, 1'b1, cn(22), rg(2), 1'b0,
         "R12 load with clear sees old record");
    do_load(cn(22), rg(2), 1'b0, "R12 R3 next load after clear");

    // clear and capture on one edge: capture wins
    step(1'b1, cn(-32768), rg(1), 1'b1, 1'b1, 1'b0, rg(0), rg(0), 1'b0, "");
    do_load(cn(-32764), rg(1), 1'b0, "R11 capture beats clear");
    do_load(cn(-32760), rg(1), 1'b0, "R6 R7 range at minimum offset");

    idle();
    idle();
    idle();
    check("R2 every load answered", sb_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule